// File: doc/BRIEF.md
# Multiplexed Readout Frame Capture

This block sits behind the 40 MHz ADC that digitizes a serially multiplexed analog front end. Each readout frame carries 16 header slots followed by 128 channel slots, one slot per clock. A data-valid input stays high for the duration of the frame. The block takes one ADC sample on every clock edge at which data-valid is high and converts the sign-magnitude ADC code to two's complement. It then tags the sample as header or channel with its index and pushes it through a 16-entry FIFO onto a valid/ready output stream.

A small state machine tracks where the block is within the frame. Its states are IDLE (waiting for data-valid), HEADER (header slots 1 to 15), CHANNEL (channel slots), TAIL (all 144 slots taken, waiting for data-valid to drop) and DRAIN (error recovery, waiting for data-valid to drop).

The transitions are as follows:
- IDLE goes to HEADER on data-valid.
- HEADER goes to CHANNEL after the sixteenth header sample.
- CHANNEL goes to TAIL after the last channel sample.
- TAIL goes to IDLE with a frame-done pulse when data-valid is low.
- TAIL goes to DRAIN with a frame-error pulse when data-valid is still high.
- HEADER or CHANNEL goes to IDLE with a frame-error pulse when data-valid falls early.
- DRAIN goes to IDLE once data-valid is low.

One instance serves one ADC. Two front-end chips read in parallel use two instances.

Top module: `frame_capture`

## Requirements
- R1: After reset, out_valid, frame_done, frame_err and ovf_flag are all 0.
- R2: Bit 9 of adc_code is the sign (1 = negative) and bits 8:0 are the magnitude. out_sample is the 11-bit two's-complement value, so both +0 and -0 give 0.
- R3: The first 16 samples of a frame leave with out_is_hdr = 1 and out_index 0 to 15, in order.
- R4: The next 128 samples leave with out_is_hdr = 0 and out_index 0 to 127, in order.
- R5: With the FIFO empty, a sample taken at a clock edge is presented on the stream (out_valid = 1) directly after that edge.
- R6: frame_done is a one-cycle pulse. It is raised after the first edge at which adc_dv is seen low following exactly 144 samples.
- R7: If adc_dv falls before 144 samples, frame_err pulses for one cycle after the edge at which it is seen low. frame_done stays low, and words already captured are still delivered.
- R8: If adc_dv is still high at the 145th edge, frame_err pulses after that edge. No further samples are written until adc_dv goes low, and the next frame starts again at header index 0.
- R9: While out_valid is high and out_ready is low, the output word is held stable. Up to 16 words are buffered without loss.
- R10: A sample arriving while the FIFO is full and not being read is dropped, and ovf_flag is set and stays set until reset.
- R11: adc_dv held low while idle produces no output words and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_code | input | 10 | Sign-magnitude ADC code |
| adc_dv | input | 1 | Data-valid, high for the frame duration |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Stream consumer accepts word |
| out_sample | output | 11 | Two's-complement sample value |
| out_is_hdr | output | 1 | 1 = header slot, 0 = channel slot |
| out_index | output | 7 | Slot index within its section |
| frame_done | output | 1 | One-cycle pulse on a clean frame end |
| frame_err | output | 1 | One-cycle pulse on a short or long frame |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |

## Verification
A sample driven before an edge becomes visible on the stream right after that edge. frame_done and frame_err also appear one edge after the sampling edge that decides them: the edge where adc_dv is seen low, or the 145th high edge. The bench drives inputs on the falling edge and tests the pulse flags at the next falling edge, which is exactly one sampling edge later. It checks stream words a moment after each falling edge, so the out_ready it sees is the value the design samples at the coming rising edge. Expected words come from a bench queue filled arithmetically as each code is driven. Successive frames together cover all 1024 ADC codes.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
    localparam int HDR_SLOTS = 16;
    localparam int CH_SLOTS  = 128;
    localparam int ALL_SLOTS = HDR_SLOTS + CH_SLOTS;
    localparam int ADC_W     = 10;
    localparam int VAL_W     = ADC_W + 1;
    localparam int IDX_W     = 7;
    localparam int POS_W     = $clog2(ALL_SLOTS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_CHANNEL,
        ST_TAIL,
        ST_DRAIN
    } fcap_state_t;

    typedef struct packed {
        logic                    is_hdr;
        logic [IDX_W-1:0]        idx;
        logic signed [VAL_W-1:0] val;
    } fcap_word_t;
endpackage

// File: rtl/fcap_conv.sv
module fcap_conv
    import fcap_pkg::*;
(
    input  logic [ADC_W-1:0]        code,
    output logic signed [VAL_W-1:0] value
);
    logic [VAL_W-1:0] mag;

    always_comb begin
        mag = {2'b00, code[ADC_W-2:0]};
        if (code[ADC_W-1]) begin
            value = $signed(VAL_W'(0) - mag);
        end else begin
            value = $signed(mag);
        end
    end
endmodule

// File: rtl/fcap_fifo.sv
module fcap_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          full, push_ok, pop_ok;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (push_ok) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop_ok) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (push && !push_ok) begin
                ovf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcap_seq.sv
module fcap_seq
    import fcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dv,
    output logic             wr_req,
    output logic             wr_hdr,
    output logic [IDX_W-1:0] wr_idx,
    output logic             done_p,
    output logic             err_p
);
    localparam logic [POS_W-1:0] LAST_HDR = POS_W'(HDR_SLOTS - 1);
    localparam logic [POS_W-1:0] LAST_ALL = POS_W'(ALL_SLOTS - 1);

    fcap_state_t     state, nstate;
    logic [POS_W-1:0] pos, npos;
    logic            ev_done, ev_err;

    always_comb begin
        nstate  = state;
        npos    = pos;
        ev_done = 1'b0;
        ev_err  = 1'b0;
        wr_req  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                npos = '0;
                if (dv) begin
                    wr_req = 1'b1;
                    npos   = POS_W'(1);
                    nstate = (HDR_SLOTS == 1) ? ST_CHANNEL : ST_HEADER;
                end
            end
            ST_HEADER: begin
                if (!dv) begin
                    ev_err = 1'b1;
                    nstate = ST_IDLE;
                    npos   = '0;
                end else begin
                    wr_req = 1'b1;
                    npos   = pos + 1'b1;
                    if (pos == LAST_HDR) nstate = ST_CHANNEL;
                end
            end
            ST_CHANNEL: begin
                if (!dv) begin
                    ev_err = 1'b1;
                    nstate = ST_IDLE;
                    npos   = '0;
                end else begin
                    wr_req = 1'b1;
                    npos   = pos + 1'b1;
                    if (pos == LAST_ALL) nstate = ST_TAIL;
                end
            end
            ST_TAIL: begin
                npos = '0;
                if (dv) begin
                    ev_err = 1'b1;
                    nstate = ST_DRAIN;
                end else begin
                    ev_done = 1'b1;
                    nstate  = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                npos = '0;
                if (!dv) nstate = ST_IDLE;
            end
            default: begin
                nstate = ST_IDLE;
                npos   = '0;
            end
        endcase
    end

    assign wr_hdr = (pos < POS_W'(HDR_SLOTS));
    assign wr_idx = wr_hdr ? IDX_W'(pos) : IDX_W'(pos - POS_W'(HDR_SLOTS));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else begin
            state <= nstate;
            pos   <= npos;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_p <= 1'b0;
            err_p  <= 1'b0;
        end else begin
            done_p <= ev_done;
            err_p  <= ev_err;
        end
    end
endmodule

// File: rtl/frame_capture.sv
module frame_capture
    import fcap_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADC_W-1:0]        adc_code,
    input  logic                    adc_dv,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [VAL_W-1:0] out_sample,
    output logic                    out_is_hdr,
    output logic [IDX_W-1:0]        out_index,
    output logic                    frame_done,
    output logic                    frame_err,
    output logic                    ovf_flag
);
    localparam int WORD_W = $bits(fcap_word_t);

    logic signed [VAL_W-1:0] conv_val;
    logic                    wr_req, wr_hdr, fifo_empty;
    logic [IDX_W-1:0]        wr_idx;
    fcap_word_t              wr_word, rd_word;

    fcap_conv u_conv (
        .code  (adc_code),
        .value (conv_val)
    );

    fcap_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .dv     (adc_dv),
        .wr_req (wr_req),
        .wr_hdr (wr_hdr),
        .wr_idx (wr_idx),
        .done_p (frame_done),
        .err_p  (frame_err)
    );

    always_comb begin
        wr_word.is_hdr = wr_hdr;
        wr_word.idx    = wr_idx;
        wr_word.val    = conv_val;
    end

    fcap_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (WORD_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_req),
        .din   (wr_word),
        .pop   (out_ready),
        .dout  (rd_word),
        .empty (fifo_empty),
        .ovf   (ovf_flag)
    );

    assign out_valid  = !fifo_empty;
    assign out_sample = rd_word.val;
    assign out_is_hdr = rd_word.is_hdr;
    assign out_index  = rd_word.idx;
endmodule

// File: rtl/fcap_chk.sv
module fcap_chk
    import fcap_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    adc_dv,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic signed [VAL_W-1:0] out_sample,
    input logic                    out_is_hdr,
    input logic [IDX_W-1:0]        out_index,
    input logic                    frame_done,
    input logic                    frame_err,
    input logic                    ovf_flag
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R6

    AST_DONE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !$past(adc_dv)); // R6

    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_err)); // R7

    AST_HDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_hdr) |-> (out_index < IDX_W'(HDR_SLOTS))); // R3

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)
            && $stable(out_is_hdr) && $stable(out_index))); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R10
endmodule

bind frame_capture fcap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_dv     (adc_dv),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .out_is_hdr (out_is_hdr),
    .out_index  (out_index),
    .frame_done (frame_done),
    .frame_err  (frame_err),
    .ovf_flag   (ovf_flag)
);

// File: tb/frame_capture_tb.sv
module frame_capture_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [9:0]        adc_code = '0;
    logic              adc_dv = 1'b0;
    logic              out_valid;
    logic              rdy_lvl = 1'b1;
    logic              tog_en = 1'b0;
    logic [7:0]        tcnt = '0;
    logic              out_ready;
    logic signed [10:0] out_sample;
    logic              out_is_hdr;
    logic [6:0]        out_index;
    logic              frame_done, frame_err, ovf_flag;

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    int base = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) tcnt <= tcnt + 8'd1;
    assign out_ready = tog_en ? (tcnt[1:0] != 2'b00) : rdy_lvl;

    frame_capture u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .adc_code   (adc_code),
        .adc_dv     (adc_dv),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sample (out_sample),
        .out_is_hdr (out_is_hdr),
        .out_index  (out_index),
        .frame_done (frame_done),
        .frame_err  (frame_err),
        .ovf_flag   (ovf_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pack_exp(input int code, input int k);
        int m = code & 511;
        int v = (code & 512) != 0 ? -m : m;
        int hdr = (k < 16) ? 1 : 0;
        int idx = (k < 16) ? k : k - 16;
        return (hdr << 18) | (idx << 11) | (v & 2047);
    endfunction

    // stream monitor: evaluated just after the falling edge, matching the next rising edge
    always @(negedge clk) begin
        #0.5;
        if (rst_n && out_valid && out_ready) begin
            int act;
            act = {13'd0, out_is_hdr, out_index, out_sample};
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3/R4 unexpected word", act, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(act == e, "R2/R3/R4 word", act, e);
            end
        end
    end

    // drive n samples; flags tested one sampling edge after the deciding edge
    task automatic run_frame(input int n, input bit lat_chk);
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (lat_chk && k == 1) begin
                check(out_valid == 1'b1, "R5 latency valid", out_valid, 1);
                check({out_is_hdr, out_index} == 8'h80, "R5 first word tag",
                      {out_is_hdr, out_index}, 8'h80);
            end
            if (k == 145 && n > 144) begin
                check(frame_err == 1'b1, "R8 long frame error", frame_err, 1);
            end
            if (k < n) begin
                int code = (base + k) % 1024;
                adc_code = 10'(code);
                adc_dv   = 1'b1;
                if (k < 144) exp_q.push_back(pack_exp(code, k));
            end else begin
                adc_dv = 1'b0;
            end
        end
        @(negedge clk);
        if (n == 144) begin
            check(frame_done == 1'b1, "R6 done pulse", frame_done, 1);
            check(frame_err == 1'b0, "R6 no error", frame_err, 0);
        end else if (n < 144) begin
            check(frame_err == 1'b1, "R7 short frame error", frame_err, 1);
            check(frame_done == 1'b0, "R7 no done", frame_done, 0);
        end else begin
            check(frame_done == 1'b0, "R8 no done", frame_done, 0);
        end
        @(negedge clk);
        check(frame_done == 1'b0 && frame_err == 1'b0, "R6 pulse width",
              {frame_done, frame_err}, 0);
        base += n;
    endtask

    task automatic drain_check(input string req);
        repeat (60) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(frame_done == 0 && frame_err == 0, "R1 pulses", {frame_done, frame_err}, 0);
        check(ovf_flag == 0, "R1 ovf", ovf_flag, 0);
        rst_n = 1'b1;

        // R11: idle with dv low
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(out_valid == 0 && frame_done == 0 && frame_err == 0, "R11 idle quiet",
                  {out_valid, frame_done, frame_err}, 0);
        end

        // R2/R3/R4/R6: clean frames, all 1024 codes covered
        run_frame(144, 1'b1);
        for (int f = 0; f < 7; f++) run_frame(144, 1'b0);
        drain_check("R2/R3/R4 all words delivered");

        // R7: short frames, in header and in channel section
        run_frame(10, 1'b0);
        run_frame(40, 1'b0);
        drain_check("R7 captured words kept");

        // R8: long frame then normal frame restarts at H0
        run_frame(150, 1'b0);
        run_frame(144, 1'b0);
        drain_check("R8 restart at header 0");

        // R9: toggling ready
        tog_en = 1'b1;
        run_frame(40, 1'b0);
        drain_check("R9 no loss under toggling ready");
        tog_en = 1'b0;

        // R9: full stall of exactly 16 words
        rdy_lvl = 1'b0;
        run_frame(16, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(out_valid == 1 && {13'd0, out_is_hdr, out_index, out_sample} == exp_q[0],
                  "R9 held word", {13'd0, out_is_hdr, out_index, out_sample}, exp_q[0]);
        end
        check(ovf_flag == 0, "R9 no overflow at 16", ovf_flag, 0);
        rdy_lvl = 1'b1;
        drain_check("R9 16 buffered words");

        // R10: overflow while stalled
        rdy_lvl = 1'b0;
        for (int k = 0; k <= 20; k++) begin
            @(negedge clk);
            if (k < 20) begin
                int code = (base + k) % 1024;
                adc_code = 10'(code);
                adc_dv   = 1'b1;
                if (k < 16) exp_q.push_back(pack_exp(code, k));
            end else begin
                adc_dv = 1'b0;
            end
        end
        base += 20;
        repeat (2) @(negedge clk);
        check(ovf_flag == 1, "R10 overflow set", ovf_flag, 1);
        rdy_lvl = 1'b1;
        drain_check("R10 only first 16 kept");
        check(ovf_flag == 1, "R10 overflow sticky", ovf_flag, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule